// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler

This block decides when a DDR SDRAM receives auto-refresh commands. A refresh-interval timer pulses `refi_tick` once per refresh interval. Each pulse adds one refresh to an owed-refresh count. The main command arbiter signals through `slot_idle` when it can give up the command bus. While the arbiter stays busy, owed refreshes are deferred. Once the owed count reaches its ceiling (eight by default), the block raises `ref_urgent` and takes the bus whether the arbiter is idle or not.

A refresh sequence begins with a precharge-all whenever the arbiter reports that a bank may be open. The refresh then follows exactly the row-precharge time later. After that, refreshes repeat back to back, one recovery time apart, until the owed count is cleared or the arbiter takes the bus back. A sequence started under urgency always runs until the owed count reaches zero. `ref_busy` is high from the first command of a sequence to the end of the last recovery window, so the arbiter can hold back activates. CKE stays high, and no row address is driven, because the memory keeps its own refresh row counter. All timings are parameters counted in clock cycles.

Top module: `ddr_refresh_sched`

## Requirements
- R1: After a synchronous active-low reset, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), cke=1, ref_busy=0 and ref_urgent=0.
- R2: A refresh is one cycle with cs_n=0, ras_n=0, cas_n=0, we_n=1 and a10=0. Every cycle without a command carries NOP. cke is 1 at all times.
- R3: Each refi_tick adds one owed refresh, and each refresh issued removes one. Over a run, the number of refreshes issued equals the number of ticks given.
- R4: No command is issued while nothing is owed. No command is issued while slot_idle=0 and fewer than MAX_DEBT refreshes are owed.
- R5: ref_urgent is high exactly when MAX_DEBT refreshes are owed. From that point the block starts a sequence in the next cycle, regardless of slot_idle, and issues refreshes until nothing is owed.
- R6: When banks_open=1 at the start of a sequence, a precharge-all is issued first (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1). The first refresh follows exactly T_RP cycles later.
- R7: Refreshes within one sequence are exactly T_RFC cycles apart.
- R8: ref_busy is high from the cycle of the first command of a sequence through T_RFC-1 cycles after its last refresh, and low in every other cycle.
- R9: A non-urgent sequence ends after the recovery of a refresh if slot_idle=0 at that point. The remaining owed refreshes are issued later, once slot_idle returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| refi_tick | input | 1 | One-cycle pulse per refresh interval |
| slot_idle | input | 1 | Arbiter offers the command bus |
| banks_open | input | 1 | Some bank may still be open |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| a10 | output | 1 | Address bit 10, high for precharge-all |
| ref_busy | output | 1 | Refresh sequence in progress; block activates |
| ref_urgent | output | 1 | Owed refreshes at ceiling |

## Verification
The bench compares the pins, the busy flag and the urgent flag against a behavioural model on every clock. It runs four input patterns. In the first, ticks arrive while the arbiter is busy and the bus is released afterwards; this separates deferral from draining and measures refresh spacing. In the second, a single tick arrives with a bank open; this isolates the precharge-to-refresh gap. The third reaches the ceiling with the arbiter never idle, which shows that urgency overrides the arbiter and that the whole debt is cleared. The fourth withdraws the bus partway through a drain, to show that a non-urgent sequence stops and resumes later without losing refreshes.

// File: rtl/ddr_ref_pkg.sv
// Shared types for the refresh scheduler: command kinds and sequencer states.
package ddr_ref_pkg;
    typedef enum logic [1:0] {CMD_NOP, CMD_PREA, CMD_REF} ref_cmd_e;
    typedef enum logic [1:0] {ST_IDLE, ST_PRE_WAIT, ST_RECOVER} ref_state_e;
endpackage

// File: rtl/ref_debt_ctr.sv
// Owed-refresh counter. It adds one per interval tick, removes one per issued
// refresh and saturates at MAX_DEBT. It assumes that a refresh is never
// issued while nothing is owed.
module ref_debt_ctr #(
    parameter int MAX_DEBT = 8,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          issue,
    output logic [DW-1:0] debt,
    output logic          nonzero,
    output logic          urgent
);
    logic [DW-1:0] debt_q;

    // Update the owed count on each tick or issued refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (tick && !issue) begin
            if (debt_q != DW'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
        end else if (!tick && issue) begin
            debt_q <= debt_q - 1'b1;
        end
    end

    assign debt    = debt_q;
    assign nonzero = (debt_q != '0);
    assign urgent  = (debt_q == DW'(MAX_DEBT));

    // R3
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= DW'(MAX_DEBT));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> debt_q != '0);
    // R3
    debt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !issue && debt_q != DW'(MAX_DEBT)) |=> debt_q == $past(debt_q) + 1'b1);
endmodule

// File: rtl/ref_seq_fsm.sv
// Refresh sequencer. It issues a precharge-all when a bank may be open, waits
// T_RP cycles, then issues refreshes spaced T_RFC apart while refreshes are
// owed and the bus is granted. A sequence begun under urgency runs until
// nothing is owed. It assumes T_RP >= 1 and T_RFC >= 1.
module ref_seq_fsm
    import ddr_ref_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RFC = 10,
    localparam int TMAX = (T_RFC > T_RP) ? T_RFC : T_RP,
    localparam int TW   = $clog2(TMAX) + 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     debt_nz,
    input  logic     urgent,
    input  logic     slot_idle,
    input  logic     banks_open,
    output ref_cmd_e cmd,
    output logic     issue_ref,
    output logic     busy
);
    ref_state_e state_q, state_d;
    ref_cmd_e   cmd_q, cmd_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic forced_q, forced_d;
    logic go, cont;

    assign go   = debt_nz && (slot_idle || urgent);
    assign cont = debt_nz && (slot_idle || urgent || forced_q);

    // Choose the next command, state and wait count.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cmd_d    = CMD_NOP;
        forced_d = forced_q;
        case (state_q)
            ST_IDLE: if (go) begin
                forced_d = urgent;
                if (banks_open) begin
                    cmd_d   = CMD_PREA;
                    state_d = ST_PRE_WAIT;
                    cnt_d   = TW'(T_RP - 1);
                end else begin
                    cmd_d   = CMD_REF;
                    state_d = ST_RECOVER;
                    cnt_d   = TW'(T_RFC - 1);
                end
            end
            ST_PRE_WAIT: if (cnt_q == '0) begin
                cmd_d   = CMD_REF;
                state_d = ST_RECOVER;
                cnt_d   = TW'(T_RFC - 1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            default: if (cnt_q == '0) begin
                if (cont) begin
                    cmd_d = CMD_REF;
                    cnt_d = TW'(T_RFC - 1);
                end else begin
                    state_d  = ST_IDLE;
                    forced_d = 1'b0;
                end
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    // Register the state, the command and the wait count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CMD_NOP;
            cnt_q    <= '0;
            forced_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cmd_q    <= cmd_d;
            cnt_q    <= cnt_d;
            forced_q <= forced_d;
        end
    end

    assign cmd       = cmd_q;
    assign issue_ref = (cmd_d == CMD_REF);
    assign busy      = (state_q != ST_IDLE);

    // R5
    urgent_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && urgent) |=> (cmd_q != CMD_NOP));
    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !slot_idle && !urgent) |=> (cmd_q == CMD_NOP));
    // R6
    prea_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PREA) |=> (cmd_q == CMD_NOP));
endmodule

// File: rtl/ref_pin_enc.sv
// Converts a command kind to the active-low command pins and address bit 10.
// It is purely combinational; clock enable is handled elsewhere.
module ref_pin_enc
    import ddr_ref_pkg::*;
(
    input  ref_cmd_e cmd,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n,
    output logic     a10
);
    // Decode the command to pin levels.
    always_comb begin
        {cs_n, ras_n, cas_n, we_n, a10} = 5'b0_111_0;
        case (cmd)
            CMD_PREA: {cs_n, ras_n, cas_n, we_n, a10} = 5'b0_010_1;
            CMD_REF:  {cs_n, ras_n, cas_n, we_n, a10} = 5'b0_001_0;
            default:  {cs_n, ras_n, cas_n, we_n, a10} = 5'b0_111_0;
        endcase
    end
endmodule

// File: rtl/ddr_refresh_sched.sv
// Top level of the auto-refresh scheduler. It ties together the owed-refresh
// counter, the sequencer and the pin encoder, and holds CKE high. It assumes
// that banks_open is low only when every bank has been idle for at least T_RP.
module ddr_refresh_sched
    import ddr_ref_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10,
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refi_tick,
    input  logic slot_idle,
    input  logic banks_open,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic a10,
    output logic ref_busy,
    output logic ref_urgent
);
    localparam int DW   = $clog2(MAX_DEBT + 1);
    localparam int TMAX = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int CW   = $clog2(TMAX + 1) + 1;

    logic [DW-1:0] debt;
    logic debt_nz, urgent, issue_ref;
    ref_cmd_e cmd;

    ref_debt_ctr #(.MAX_DEBT(MAX_DEBT)) i_debt (
        .clk(clk), .rst_n(rst_n), .tick(refi_tick), .issue(issue_ref),
        .debt(debt), .nonzero(debt_nz), .urgent(urgent)
    );

    ref_seq_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) i_seq (
        .clk(clk), .rst_n(rst_n), .debt_nz(debt_nz), .urgent(urgent),
        .slot_idle(slot_idle), .banks_open(banks_open),
        .cmd(cmd), .issue_ref(issue_ref), .busy(ref_busy)
    );

    ref_pin_enc i_enc (
        .cmd(cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a10(a10)
    );

    assign cke        = 1'b1;
    assign ref_urgent = urgent;

    // Checker counters: cycles since the last refresh and the last precharge.
    logic [CW-1:0] since_ref, since_pre;
    logic seen_ref, pre_pending;

    // Track the gaps after refresh and precharge commands for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref   <= '0;
            since_pre   <= '0;
            seen_ref    <= 1'b0;
            pre_pending <= 1'b0;
        end else begin
            if (cmd == CMD_REF) begin
                since_ref   <= CW'(1);
                seen_ref    <= 1'b1;
                pre_pending <= 1'b0;
            end else if (since_ref != CW'(TMAX)) begin
                since_ref <= since_ref + 1'b1;
            end
            if (cmd == CMD_PREA) begin
                since_pre   <= CW'(1);
                pre_pending <= 1'b1;
            end else if (since_pre != CW'(TMAX)) begin
                since_pre <= since_pre + 1'b1;
            end
        end
    end

    // R7
    rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && seen_ref) |-> since_ref >= CW'(T_RFC));
    // R6
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && pre_pending) |-> since_pre >= CW'(T_RP));
    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> ref_busy);
    // R2
    cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke && !cs_n);
endmodule

// File: tb/test_ddr_refresh_sched.sv
// Bench for the refresh scheduler: a behavioural reference model compared
// every clock, plus directed scenario checks.
module test_ddr_refresh_sched;
    localparam int T_RP = 3, T_RFC = 10, MAX_DEBT = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic refi_tick = 1'b0, slot_idle = 1'b0, banks_open = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, a10, ref_busy, ref_urgent;

    ddr_refresh_sched #(.T_RP(T_RP), .T_RFC(T_RFC), .MAX_DEBT(MAX_DEBT)) i_ddr_refresh_sched (
        .clk(clk), .rst_n(rst_n), .refi_tick(refi_tick), .slot_idle(slot_idle),
        .banks_open(banks_open), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .a10(a10), .ref_busy(ref_busy), .ref_urgent(ref_urgent)
    );

    always #2 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model: owed count, phase (0 idle, 1 after precharge, 2 recovery).
    int m_debt = 0, m_phase = 0, m_left = 0, m_cmd = 0;
    bit m_forced = 0;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_debt = 0; m_phase = 0; m_left = 0; m_cmd = 0; m_forced = 0;
        end else begin
            bit took;
            took = 0;
            m_cmd = 0;
            if (m_phase == 0) begin
                if (m_debt > 0 && (slot_idle || m_debt == MAX_DEBT)) begin
                    m_forced = (m_debt == MAX_DEBT);
                    if (banks_open) begin m_cmd = 1; m_phase = 1; m_left = T_RP - 1; end
                    else begin m_cmd = 2; took = 1; m_phase = 2; m_left = T_RFC - 1; end
                end
            end else if (m_left > 0) begin
                m_left--;
            end else if (m_phase == 1) begin
                m_cmd = 2; took = 1; m_phase = 2; m_left = T_RFC - 1;
            end else if (m_debt > 0 && (slot_idle || m_forced || m_debt == MAX_DEBT)) begin
                m_cmd = 2; took = 1; m_left = T_RFC - 1;
            end else begin
                m_phase = 0; m_forced = 0;
            end
            if (refi_tick && !took && m_debt < MAX_DEBT) m_debt++;
            else if (!refi_tick && took) m_debt--;
        end
    end

    // Monitor: compare with the model and collect scenario statistics.
    int refs = 0, pres = 0, last_ref = -1, last_pre = -1, min_gap = 1 << 30, max_gap = 0;
    int pre_gap = -1, busy_cyc = 0;
    bit urg_seen = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int got, exp;
            got = {cs_n, ras_n, cas_n, we_n, a10};
            exp = (m_cmd == 1) ? 5'b00101 : (m_cmd == 2) ? 5'b00010 : 5'b01110;
            chk(got == exp, (m_cmd == 1) ? "R6 pins" : "R2 pins", got, exp);
            chk(cke == 1'b1, "R2 cke", cke, 1);
            chk(ref_busy == (m_phase != 0), "R8 busy", ref_busy, m_phase != 0);
            chk(ref_urgent == (m_debt == MAX_DEBT), "R5 urgent", ref_urgent, m_debt == MAX_DEBT);
            if (ref_busy) busy_cyc++;
            if (ref_urgent) urg_seen = 1;
            if (got == 5'b00101) begin pres++; last_pre = cyc; end
            if (got == 5'b00010) begin
                if (last_ref >= 0) begin
                    if (cyc - last_ref < min_gap) min_gap = cyc - last_ref;
                    if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                end
                if (last_pre >= 0 && pre_gap < 0) pre_gap = cyc - last_pre;
                refs++; last_ref = cyc;
            end
        end
    end

    task automatic clr_stats();
        refs = 0; pres = 0; last_ref = -1; last_pre = -1; min_gap = 1 << 30;
        max_gap = 0; pre_gap = -1; busy_cyc = 0; urg_seen = 0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) refi_tick = 1'b1;
            @(negedge clk) refi_tick = 1'b0;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        @(negedge clk) rst_n = 1'b1;
        // R1: state after reset
        chk({cs_n, ras_n, cas_n, we_n, a10} == 5'b01110, "R1 pins", {cs_n, ras_n, cas_n, we_n, a10}, 5'b01110);
        chk(cke && !ref_busy && !ref_urgent, "R1 flags", {cke, ref_busy, ref_urgent}, 3'b100);

        // Pattern A: deferral with the arbiter busy, then draining.
        clr_stats();
        ticks(3);
        wait_cyc(30);
        chk(refs == 0 && busy_cyc == 0, "R4 deferred", refs, 0);
        slot_idle = 1'b1;
        wait_cyc(3 * T_RFC + 10);
        chk(refs == 3, "R3 drained", refs, 3);
        chk(min_gap == T_RFC && max_gap == T_RFC, "R7 spacing", max_gap, T_RFC);
        chk(busy_cyc == 3 * T_RFC, "R8 busy span", busy_cyc, 3 * T_RFC);

        // Pattern B: a bank may be open, so precharge-all comes first.
        clr_stats();
        banks_open = 1'b1;
        ticks(1);
        wait_cyc(T_RP + T_RFC + 10);
        chk(pres == 1 && refs == 1, "R6 prea count", pres * 10 + refs, 11);
        chk(pre_gap == T_RP, "R6 prea gap", pre_gap, T_RP);
        chk(busy_cyc == T_RP + T_RFC, "R8 busy span pre", busy_cyc, T_RP + T_RFC);
        banks_open = 1'b0;

        // Pattern C: the ceiling is reached with the arbiter never idle.
        clr_stats();
        slot_idle = 1'b0;
        ticks(MAX_DEBT);
        wait_cyc(MAX_DEBT * T_RFC + 20);
        chk(urg_seen, "R5 urgent raised", urg_seen, 1);
        chk(refs == MAX_DEBT, "R5 forced drain", refs, MAX_DEBT);
        chk(min_gap == T_RFC && max_gap == T_RFC, "R7 forced spacing", min_gap, T_RFC);
        chk(!ref_busy && !ref_urgent, "R8 idle after", ref_busy, 0);

        // Pattern D: the bus is withdrawn partway through a drain.
        clr_stats();
        ticks(4);
        slot_idle = 1'b1;
        while (refs < 2) @(negedge clk);
        slot_idle = 1'b0;
        wait_cyc(40);
        chk(refs == 2, "R9 stop", refs, 2);
        chk(!ref_busy, "R9 not busy", ref_busy, 0);
        slot_idle = 1'b1;
        wait_cyc(40);
        chk(refs == 4, "R9 resume", refs, 4);
        chk(refs == 4 && pres == 0, "R3 balance", refs, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule